// File: doc/BRIEF.md
# Addressed Serial Quad-DAC Loader

This block is the digital front end of a four-channel, 14-bit digital-to-analog converter. A host drives a framed serial bus: a clock line, a data line and an active-low frame strobe. A frame holds 24 bits. Its top five bits carry a device address, which is compared against five strap pins so that as many as 32 devices can share one bus. Two bits select one of four channels. The low 14 bits are the output code. An accepted frame writes its code into that channel's staging register.

Two level-sensitive controls decide when staged codes reach the latches that drive the converters. The active-low load control copies staged values into the latches. The active-low clear control forces every channel's clamp flag, so the analog side then drives the sense-ground level. A clamp flag is released only when the load control is taken low after the clear control has returned high. All bus and control pins are asynchronous to the system clock and pass through two-flop synchronisers before any edge or level is acted on.

Top module: `sqdLoader`

## Requirements
- R1: After reset every latch output on `dacCode` is 0, all four `clamped` bits are 1 and `frameErr` is 0.
- R2: While `fsyncN` is low, one bit of `din` is taken MSB first at each rising edge of `sclk`. The frame is acted on at the rising edge of `fsyncN`. Bits [23:19] hold the device address, bits [17:16] the channel number n (0 to 3), and bits [13:0] the code. Channel n appears on `dacCode[14*n +: 14]`. Bits 18, 15 and 14 are ignored.
- R3: While `pkgAddrIgnore` is 0, a frame whose address field differs from `pkgStrap` changes neither a staging register nor a latch.
- R4: While `pkgAddrIgnore` is 1, a 24-bit frame is accepted whatever its address field, and it is still steered by its channel field.
- R5: While `ldacN` is high, an accepted frame changes only the staging register and `dacCode` stays put. A later low level on `ldacN` (with `clrN` high) loads all four latches from their staging registers.
- R6: If `ldacN` is low and `clrN` is high when `fsyncN` rises, the addressed channel's latch takes the new code in the same update.
- R7: While `clrN` is low, all `clamped` bits are 1 and `ldacN` has no effect on the latches.
- R8: After `clrN` returns high, `clamped` stays all ones until `ldacN` is low. It then clears to 0 and the latches reload from the staging registers.
- R9: A frame that ends after any bit count other than 24 is discarded and sets `frameErr`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial bus clock, asynchronous |
| din | input | 1 | Serial data |
| fsyncN | input | 1 | Active-low frame strobe |
| pkgStrap | input | 5 | Strapped device address |
| pkgAddrIgnore | input | 1 | 1 = accept any device address |
| ldacN | input | 1 | Active-low level load control |
| clrN | input | 1 | Active-low level clear control |
| dacCode | output | 56 | Four 14-bit latch values, channel 0 in the low bits |
| clamped | output | 4 | Per-channel flag: output held at sense ground |
| frameErr | output | 1 | Sticky short/long frame flag |

## Verification
The bench sends frames whose address differs from the strap. A design that ignored the address would let a foreign write reach a latch, and the same frame under broadcast must land on the addressed lane. Frames of 23 and 25 bits are sent. A design with a loose bit count would load a shifted code and leave the error flag low. Set reserved and leading bits expose a design that takes the wrong field positions. The clear sequence drives the load control low during the clear and then releases the clear with the load control high. A design that released the clamp on the clear edge, or that let the load control act during the clear, would show changed latches or dropped flags.

// File: rtl/sqdPkg.sv
package sqdPkg;
  typedef struct packed {
    logic shiftEn;
    logic frameWrite;
    logic latchAll;
    logic forceClamp;
  } strobeT;
endpackage

// File: rtl/sqdSync.sv
module sqdSync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < STAGES; s++) stage[s] <= RST_VAL;
    end else begin
      stage[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stage[s] <= stage[s-1];
    end
  end

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/sqdCtrl.sv
module sqdCtrl
  import sqdPkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int PKG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclkS,
  input  logic             fsyncS,
  input  logic             ldacS,
  input  logic             clrS,
  input  logic [PKG_W-1:0] pkgField,
  input  logic [PKG_W-1:0] pkgStrap,
  input  logic             pkgAddrIgnore,
  output strobeT           strb,
  output logic             frameErr
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic sclkPrev, fsyncPrev;
  logic sclkRise, fsyncFall, fsyncRise;
  logic [CNT_W-1:0] bitCnt;
  logic addrOk, countOk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev  <= 1'b0;
      fsyncPrev <= 1'b1;
    end else begin
      sclkPrev  <= sclkS;
      fsyncPrev <= fsyncS;
    end
  end

  assign sclkRise  = sclkS & ~sclkPrev;
  assign fsyncFall = ~fsyncS & fsyncPrev;
  assign fsyncRise = fsyncS & ~fsyncPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (fsyncFall) bitCnt <= '0;
    else if (strb.shiftEn && bitCnt != CNT_SAT) bitCnt <= bitCnt + 1'b1;
  end

  assign addrOk  = pkgAddrIgnore || (pkgField == pkgStrap);
  assign countOk = (bitCnt == CNT_FULL);

  always_comb begin
    strb.shiftEn    = sclkRise & ~fsyncS;
    strb.frameWrite = fsyncRise & countOk & addrOk;
    strb.latchAll   = ~ldacS & clrS;
    strb.forceClamp = ~clrS;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) frameErr <= 1'b0;
    else if (fsyncRise && !countOk) frameErr <= 1'b1;
  end
endmodule

// File: rtl/sqdDatapath.sv
module sqdDatapath
  import sqdPkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int DATA_W = 16,
  parameter int CODE_W = 14,
  parameter int PKG_W = 5,
  parameter int CHANNELS = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  strobeT                     strb,
  input  logic                       dinS,
  output logic [PKG_W-1:0]           pkgField,
  output logic [CHANNELS*CODE_W-1:0] dacCode,
  output logic [CHANNELS-1:0]        clamped
);
  localparam int CH_W = $clog2(CHANNELS);
  localparam int RSV_HI = FRAME_W - PKG_W - 1;
  localparam int RSV_LO = DATA_W + CH_W;

  logic [FRAME_W-1:0] shiftReg;
  logic [CH_W-1:0]    chSel;
  logic [CODE_W-1:0]  newCode;
  logic               unusedFrameBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftReg <= '0;
    else if (strb.shiftEn) shiftReg <= {shiftReg[FRAME_W-2:0], dinS};
  end

  assign pkgField = shiftReg[FRAME_W-1 -: PKG_W];
  assign chSel    = shiftReg[DATA_W +: CH_W];
  assign newCode  = shiftReg[CODE_W-1:0];
  assign unusedFrameBits = ^{shiftReg[RSV_HI:RSV_LO], shiftReg[DATA_W-1:CODE_W]};

  for (genvar i = 0; i < CHANNELS; i++) begin : g_chan
    logic [CODE_W-1:0] stageReg, latchReg;
    logic              hit, clampReg;

    assign hit = strb.frameWrite && (chSel == CH_W'(i));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageReg <= '0;
        latchReg <= '0;
        clampReg <= 1'b1;
      end else begin
        if (hit) stageReg <= newCode;
        if (strb.latchAll) latchReg <= hit ? newCode : stageReg;
        if (strb.forceClamp) clampReg <= 1'b1;
        else if (strb.latchAll) clampReg <= 1'b0;
      end
    end

    assign dacCode[i*CODE_W +: CODE_W] = latchReg;
    assign clamped[i] = clampReg;
  end
endmodule

// File: rtl/sqdLoader.sv
module sqdLoader
  import sqdPkg::*;
#(
  parameter int FRAME_W = 24,
  parameter int DATA_W = 16,
  parameter int CODE_W = 14,
  parameter int PKG_W = 5,
  parameter int CHANNELS = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       sclk,
  input  logic                       din,
  input  logic                       fsyncN,
  input  logic [PKG_W-1:0]           pkgStrap,
  input  logic                       pkgAddrIgnore,
  input  logic                       ldacN,
  input  logic                       clrN,
  output logic [CHANNELS*CODE_W-1:0] dacCode,
  output logic [CHANNELS-1:0]        clamped,
  output logic                       frameErr
);
  logic [4:0] pinsS;
  logic [PKG_W-1:0] pkgField;
  strobeT strb;

  sqdSync #(.W(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({clrN, ldacN, fsyncN, din, sclk}),
    .syncOut(pinsS)
  );

  sqdCtrl #(.FRAME_W(FRAME_W), .PKG_W(PKG_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .sclkS(pinsS[0]), .fsyncS(pinsS[2]), .ldacS(pinsS[3]), .clrS(pinsS[4]),
    .pkgField(pkgField), .pkgStrap(pkgStrap), .pkgAddrIgnore(pkgAddrIgnore),
    .strb(strb), .frameErr(frameErr)
  );

  sqdDatapath #(.FRAME_W(FRAME_W), .DATA_W(DATA_W), .CODE_W(CODE_W),
                .PKG_W(PKG_W), .CHANNELS(CHANNELS)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .dinS(pinsS[1]),
    .pkgField(pkgField), .dacCode(dacCode), .clamped(clamped)
  );
endmodule

// File: rtl/sqdLoaderChecker.sv
module sqdLoaderChecker
  import sqdPkg::*;
#(
  parameter int CODE_W = 14,
  parameter int CHANNELS = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input strobeT                     strb,
  input logic [CHANNELS*CODE_W-1:0] dacCode,
  input logic [CHANNELS-1:0]        clamped,
  input logic                       frameErr
);
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);

  assert_good_frame_no_err_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.frameWrite && !frameErr |=> !frameErr);

  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.latchAll |=> $stable(dacCode));

  assert_clear_forces_R7: assert property (@(posedge clk) disable iff (!rstN)
    strb.forceClamp |=> (clamped == {CHANNELS{1'b1}}));

  assert_clamp_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clamped == {CHANNELS{1'b1}}) && !strb.latchAll |=> (clamped == {CHANNELS{1'b1}}));

  assert_shift_vs_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftEn |-> !strb.frameWrite);
endmodule

bind sqdLoader sqdLoaderChecker #(.CODE_W(CODE_W), .CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rstN(rstN), .strb(strb),
  .dacCode(dacCode), .clamped(clamped), .frameErr(frameErr)
);

// File: tb/sqdLoader_tb.sv
module sqdLoader_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] STRAP = 5'h13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, din = 1'b0, fsyncN = 1'b1;
  logic pkgAddrIgnore = 1'b0, ldacN = 1'b1, clrN = 1'b1;
  logic [55:0] dacCode;
  logic [3:0] clamped;
  logic frameErr;

  int vectors = 0, miscompares = 0;
  logic [13:0] expIn [4];
  logic [13:0] expLatch [4];
  logic expClamp, expErr;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sqdLoader u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .din(din), .fsyncN(fsyncN),
    .pkgStrap(STRAP), .pkgAddrIgnore(pkgAddrIgnore), .ldacN(ldacN), .clrN(clrN),
    .dacCode(dacCode), .clamped(clamped), .frameErr(frameErr)
  );

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void applyLevels();
    if (!clrN) expClamp = 1'b1;
    else if (!ldacN) begin
      expClamp = 1'b0;
      for (int c = 0; c < 4; c++) expLatch[c] = expIn[c];
    end
  endfunction

  function automatic bit addrAccept(input logic [4:0] pa, input logic ign);
    return ign || (pa == STRAP);
  endfunction

  task automatic checkAll(input string tag);
    vectors++;
    for (int c = 0; c < 4; c++) begin
      if (dacCode[c*14 +: 14] !== expLatch[c]) begin
        miscompares++;
        $display("FAIL %s ch%0d code actual=%h expected=%h", tag, c, dacCode[c*14 +: 14], expLatch[c]);
      end
    end
    if (clamped !== {4{expClamp}}) begin
      miscompares++;
      $display("FAIL %s clamped actual=%b expected=%b", tag, clamped, {4{expClamp}});
    end
    if (frameErr !== expErr) begin
      miscompares++;
      $display("FAIL %s frameErr actual=%b expected=%b", tag, frameErr, expErr);
    end
  endtask

  task automatic setLevels(input logic l, input logic c);
    ldacN = l;
    clrN = c;
    waitClk(6);
    applyLevels();
  endtask

  task automatic sendFrame(input logic [4:0] pa, input logic [1:0] ch, input logic [13:0] code,
                           input logic rsv, input logic [1:0] lead, input int nbits);
    logic [23:0] word;
    word = {pa, rsv, ch, lead, code};
    fsyncN = 1'b0;
    waitClk(4);
    for (int i = 0; i < nbits; i++) begin
      din = (i < 24) ? word[23-i] : 1'b0;
      waitClk(3);
      sclk = 1'b1;
      waitClk(4);
      sclk = 1'b0;
      waitClk(1);
    end
    waitClk(4);
    fsyncN = 1'b1;
    waitClk(6);
    if (nbits != 24) expErr = 1'b1;
    else if (addrAccept(pa, pkgAddrIgnore)) expIn[ch] = code;
    applyLevels();
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc >= 200000) begin
        miscompares++;
        $display("FAIL watchdog actual=%0d cycles expected=completion", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int c = 0; c < 4; c++) begin expIn[c] = '0; expLatch[c] = '0; end
    expClamp = 1'b1;
    expErr = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    waitClk(4);
    checkAll("R1 reset state");

    // R5: staged only while load control high
    sendFrame(STRAP, 2'd2, 14'h1ABC, 1'b0, 2'b00, 24);
    checkAll("R5 staged with ldacN high");
    setLevels(1'b0, 1'b1);
    checkAll("R5 R8 load all on ldacN low");

    // R6: immediate update with ldacN low
    sendFrame(STRAP, 2'd1, 14'h0F0F, 1'b0, 2'b00, 24);
    checkAll("R6 immediate update ch1");

    // R3: address mismatch ignored
    sendFrame(STRAP ^ 5'h01, 2'd0, 14'h3FFF, 1'b0, 2'b00, 24);
    checkAll("R3 foreign address ignored");

    // R4: broadcast accepts foreign address
    pkgAddrIgnore = 1'b1;
    sendFrame(5'h0A, 2'd0, 14'h2345, 1'b0, 2'b00, 24);
    checkAll("R4 broadcast ch0");
    pkgAddrIgnore = 1'b0;

    // R2: reserved and leading bits ignored, lane 3
    sendFrame(STRAP, 2'd3, 14'h0001, 1'b1, 2'b11, 24);
    checkAll("R2 reserved bits ignored ch3");

    // R9: short and long frames
    sendFrame(STRAP, 2'd2, 14'h1111, 1'b0, 2'b00, 23);
    checkAll("R9 short frame");
    sendFrame(STRAP, 2'd2, 14'h2222, 1'b0, 2'b00, 25);
    checkAll("R9 long frame sticky");

    // R7: clear forces clamp, load control ignored
    setLevels(1'b0, 1'b0);
    checkAll("R7 clear asserted");
    sendFrame(STRAP, 2'd1, 14'h0ACE, 1'b0, 2'b00, 24);
    checkAll("R7 ldacN ignored during clear");

    // R8: clamp held after clear release until load control low
    setLevels(1'b1, 1'b0);
    setLevels(1'b1, 1'b1);
    checkAll("R8 clamp held after clear release");
    setLevels(1'b0, 1'b1);
    checkAll("R8 clamp released by ldacN low");

    // random mix
    for (int it = 0; it < 40; it++) begin
      logic [4:0] pa;
      logic [1:0] ch;
      logic [13:0] code;
      int nb;
      pa = (($urandom % 4) == 0) ? 5'($urandom) : STRAP;
      ch = 2'($urandom);
      code = 14'($urandom);
      nb = (($urandom % 10) == 0) ? 23 : 24;
      pkgAddrIgnore = (($urandom % 4) == 0);
      setLevels(1'($urandom), (($urandom % 8) != 0));
      sendFrame(pa, ch, code, 1'($urandom), 2'($urandom), nb);
      checkAll("R2 R3 R4 R5 R6 random frame");
    end
    setLevels(1'b0, 1'b1);
    checkAll("R5 final load");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule